// File: doc/BRIEF.md
# Secure-Execute Privilege Gate

This block watches the stream of retiring instructions and decides whether each one may run at the privilege it asks for. Every page carries a secure-execute attribute that arrives with the fetch. Code running in such a page can issue an enter instruction to raise a transient elevated flag. While that flag is set, privileged instructions (for example updates to key material) may run, even though the core itself still reports user mode. An exit instruction drops the flag again.

The gate raises a one-cycle fault with a two-bit cause in three cases: an enter outside a secure-execute page, a privileged instruction without elevation, and any instruction retiring outside a secure-execute page while the flag is still set. Any fault, and any trap or interrupt that the core takes, clears the flag. True supervisor mode bypasses the gate. The trap handler, the decoder and the page walker sit outside this block. The block only consumes their results: the class of each instruction, the page attribute and the trap strobe.

Top module: `sx_priv_gate`

## Requirements
- R1: After reset, `elev_o` is 0, `fault_o` is 0 and `fault_cause_o` is 2'b00.
- R2: A retiring user-mode enter (`ret_cls` = 2'b01) in a secure-execute page sets `elev_o` one cycle later without a fault. An enter while already elevated inside such a page leaves it set.
- R3: A retiring user-mode enter outside a secure-execute page, while not elevated, gives `fault_o` = 1 with cause 2'b01 one cycle later, and `elev_o` stays 0.
- R4: A retiring user-mode privileged instruction (`ret_cls` = 2'b11) while not elevated gives a fault with cause 2'b10 one cycle later, whether or not its page is secure-execute.
- R5: A privileged instruction in a secure-execute page while elevated gives no fault, and the flag stays set.
- R6: While elevated, any user-mode instruction retiring outside a secure-execute page gives a fault with cause 2'b11 and clears `elev_o` in the same cycle. This check takes priority over the class checks.
- R7: An exit (`ret_cls` = 2'b10) clears `elev_o`. An exit when not elevated changes nothing and gives no fault. A normal instruction (`ret_cls` = 2'b00) in a secure-execute page changes nothing.
- R8: `trap_take` clears `elev_o` on the next cycle and wins over an enter in the same cycle. Whenever `fault_o` is high, `elev_o` is 0.
- R9: With `sup_mode` = 1, a retiring instruction never faults and does not change `elev_o`.
- R10: Without `ret_vld` (and without a trap), `elev_o` holds and no fault is raised.
- R11: `fault_o` is a single-cycle pulse per faulting instruction, and `fault_cause_o` is 2'b00 whenever `fault_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_vld | input | 1 | An instruction retires this cycle |
| ret_cls | input | 2 | Class: 00 normal, 01 enter, 10 exit, 11 privileged |
| ret_sx_page | input | 1 | The retiring instruction lies in a secure-execute page |
| sup_mode | input | 1 | Core is in true supervisor mode |
| trap_take | input | 1 | Core takes a trap or interrupt this cycle |
| elev_o | output | 1 | Transient elevated-privilege flag |
| fault_o | output | 1 | Fault pulse for the instruction retired in the previous cycle |
| fault_cause_o | output | 2 | 01 bad enter, 10 privileged without elevation, 11 left page while elevated |

## Verification
The gate is exercised with sequences that differ only in page attribute, so that a legal enter can be told apart from an illegal one, and a privileged instruction before and after elevation. Elevated runs that leave the page on a normal, privileged, enter or exit instruction show that the leave check takes priority over the class checks. Trap, supervisor and idle cycles are mixed into elevated runs to separate a flag that holds from one that clears. A cycle model in the bench predicts flag, fault and cause on every clock.

// File: rtl/sxg_pkg.sv
package sxg_pkg;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'b00,
        CLS_ENTER  = 2'b01,
        CLS_EXIT   = 2'b10,
        CLS_PRIV   = 2'b11
    } sxg_cls_e;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'b00,
        CAUSE_BAD_ENTER = 2'b01,
        CAUSE_NO_ELEV   = 2'b10,
        CAUSE_LEFT_PAGE = 2'b11
    } sxg_cause_e;

    typedef struct packed {
        logic       elev;
        logic       fault;
        sxg_cause_e cause;
    } sxg_state_t;

endpackage

// File: rtl/sxg_check.sv
module sxg_check
    import sxg_pkg::*;
(
    input  logic       vld,
    input  logic       sup,
    input  logic       sx_page,
    input  sxg_cls_e   cls,
    input  logic       elev_q,
    output sxg_cause_e cause,
    output logic       elev_set,
    output logic       elev_clr
);

    always_comb begin
        cause    = CAUSE_NONE;
        elev_set = 1'b0;
        elev_clr = 1'b0;
        if (vld && !sup) begin
            if (elev_q && !sx_page) begin
                cause    = CAUSE_LEFT_PAGE;
                elev_clr = 1'b1;
            end else begin
                unique case (cls)
                    CLS_ENTER: begin
                        if (sx_page) elev_set = 1'b1;
                        else         cause    = CAUSE_BAD_ENTER;
                    end
                    CLS_EXIT:  elev_clr = 1'b1;
                    CLS_PRIV:  if (!elev_q) cause = CAUSE_NO_ELEV;
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sxg_regs.sv
module sxg_regs
    import sxg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trap,
    input  sxg_cause_e cause,
    input  logic       elev_set,
    input  logic       elev_clr,
    output sxg_state_t state_q
);

    sxg_state_t state_d;

    always_comb begin
        state_d       = state_q;
        state_d.cause = cause;
        state_d.fault = (cause != CAUSE_NONE);
        if (elev_set) state_d.elev = 1'b1;
        if (elev_clr || state_d.fault || trap) state_d.elev = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{elev: 1'b0, fault: 1'b0, cause: CAUSE_NONE};
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/sx_priv_gate.sv
module sx_priv_gate
    import sxg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ret_vld,
    input  logic [1:0] ret_cls,
    input  logic       ret_sx_page,
    input  logic       sup_mode,
    input  logic       trap_take,
    output logic       elev_o,
    output logic       fault_o,
    output logic [1:0] fault_cause_o
);

    sxg_cause_e cause_w;
    logic       set_w;
    logic       clr_w;
    sxg_state_t st_q;

    sxg_check u_check (
        .vld      (ret_vld),
        .sup      (sup_mode),
        .sx_page  (ret_sx_page),
        .cls      (sxg_cls_e'(ret_cls)),
        .elev_q   (st_q.elev),
        .cause    (cause_w),
        .elev_set (set_w),
        .elev_clr (clr_w)
    );

    sxg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap     (trap_take),
        .cause    (cause_w),
        .elev_set (set_w),
        .elev_clr (clr_w),
        .state_q  (st_q)
    );

    assign elev_o        = st_q.elev;
    assign fault_o       = st_q.fault;
    assign fault_cause_o = st_q.cause;

endmodule

// File: rtl/sx_priv_gate_chk.sv
module sx_priv_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ret_vld,
    input logic [1:0] ret_cls,
    input logic       ret_sx_page,
    input logic       sup_mode,
    input logic       trap_take,
    input logic       elev_o,
    input logic       fault_o,
    input logic [1:0] fault_cause_o
);

    AST_BAD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld && !sup_mode && ret_cls == 2'b01 && !ret_sx_page && !elev_o
        |=> fault_o && fault_cause_o == 2'b01 && !elev_o); // R3

    AST_PRIV_NO_ELEV: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld && !sup_mode && ret_cls == 2'b11 && !elev_o
        |=> fault_o && fault_cause_o == 2'b10); // R4

    AST_LEFT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld && !sup_mode && elev_o && !ret_sx_page
        |=> fault_o && fault_cause_o == 2'b11 && !elev_o); // R6

    AST_FAULT_DROPS_ELEV: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !elev_o); // R8

    AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !elev_o); // R8

    AST_SUP_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld && sup_mode && !trap_take |=> !fault_o && $stable(elev_o)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_vld && !trap_take |=> !fault_o && $stable(elev_o)); // R10

    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> fault_cause_o == 2'b00); // R11

endmodule

bind sx_priv_gate sx_priv_gate_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ret_vld       (ret_vld),
    .ret_cls       (ret_cls),
    .ret_sx_page   (ret_sx_page),
    .sup_mode      (sup_mode),
    .trap_take     (trap_take),
    .elev_o        (elev_o),
    .fault_o       (fault_o),
    .fault_cause_o (fault_cause_o)
);

// File: tb/sx_priv_gate_test.sv
module sx_priv_gate_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ret_vld = 1'b0;
    logic [1:0] ret_cls = 2'b00;
    logic       ret_sx_page = 1'b0;
    logic       sup_mode = 1'b0;
    logic       trap_take = 1'b0;
    logic       elev_o;
    logic       fault_o;
    logic [1:0] fault_cause_o;

    int total = 0;
    int bad = 0;

    // reference state
    int m_elev = 0;
    int m_fault = 0;
    int m_cause = 0;

    always #4 clk = ~clk;

    sx_priv_gate uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ret_vld       (ret_vld),
        .ret_cls       (ret_cls),
        .ret_sx_page   (ret_sx_page),
        .sup_mode      (sup_mode),
        .trap_take     (trap_take),
        .elev_o        (elev_o),
        .fault_o       (fault_o),
        .fault_cause_o (fault_cause_o)
    );

    task automatic compare(input string tag);
        total++;
        if (int'(elev_o) != m_elev || int'(fault_o) != m_fault || int'(fault_cause_o) != m_cause) begin
            bad++;
            $display("FAIL %s: elev/fault/cause actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                     tag, elev_o, fault_o, fault_cause_o, m_elev, m_fault, m_cause);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, compare at the next falling edge.
    task automatic step(input string tag, input int vld, input int cls, input int sx,
                        input int sup, input int trap);
        int nf;
        int nc;
        int ne;
        ret_vld     = vld[0];
        ret_cls     = cls[1:0];
        ret_sx_page = sx[0];
        sup_mode    = sup[0];
        trap_take   = trap[0];
        nf = 0; nc = 0; ne = m_elev;
        if (vld != 0 && sup == 0) begin
            if (m_elev != 0 && sx == 0) begin
                nf = 1; nc = 3;
            end else if (cls == 1) begin
                if (sx != 0) ne = 1;
                else begin nf = 1; nc = 1; end
            end else if (cls == 2) begin
                ne = 0;
            end else if (cls == 3 && m_elev == 0) begin
                nf = 1; nc = 2;
            end
        end
        if (nf != 0 || trap != 0) ne = 0;
        @(posedge clk);
        m_elev = ne; m_fault = nf; m_cause = nc;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // idle
        step("R10", 0, 1, 1, 0, 0);
        // normal code in secure page, no effect
        step("R7", 1, 0, 1, 0, 0);
        // privileged without elevation, inside and outside secure page
        step("R4", 1, 3, 1, 0, 0);
        step("R11", 1, 0, 1, 0, 0);
        step("R4", 1, 3, 0, 0, 0);
        // illegal enter
        step("R3", 1, 1, 0, 0, 0);
        // legal enter, privileged use, repeat enter
        step("R2", 1, 1, 1, 0, 0);
        step("R5", 1, 3, 1, 0, 0);
        step("R2", 1, 1, 1, 0, 0);
        step("R10", 0, 3, 0, 0, 0);
        step("R7", 1, 0, 1, 0, 0);
        // exit, then exit again
        step("R7", 1, 2, 1, 0, 0);
        step("R7", 1, 2, 1, 0, 0);
        step("R4", 1, 3, 1, 0, 0);
        // leave the page on each class while elevated
        for (int c = 0; c < 4; c++) begin
            step("R2", 1, 1, 1, 0, 0);
            step("R6", 1, c, 0, 0, 0);
            step("R11", 1, 0, 0, 0, 0);
        end
        // trap clears, trap wins over enter
        step("R2", 1, 1, 1, 0, 0);
        step("R8", 0, 0, 1, 0, 1);
        step("R8", 1, 1, 1, 0, 1);
        step("R8", 1, 1, 1, 0, 0);
        step("R8", 1, 3, 1, 0, 1);
        // supervisor bypass while elevated and not elevated
        step("R2", 1, 1, 1, 0, 0);
        step("R9", 1, 0, 0, 1, 0);
        step("R9", 1, 2, 0, 1, 0);
        step("R9", 1, 3, 1, 1, 0);
        step("R5", 1, 3, 1, 0, 0);
        step("R8", 1, 1, 0, 1, 1);
        step("R9", 1, 3, 0, 1, 0);
        step("R9", 1, 1, 0, 1, 0);
        step("R10", 0, 0, 0, 0, 0);
        // pattern sweep
        for (int i = 0; i < 400; i++) begin
            step("R11", 1, (i * 7 + i / 5) % 4, ((i * 3) / 4) % 2 == 0 ? 1 : ((i % 11) == 0 ? 0 : 1),
                 (i % 13) == 5 ? 1 : 0, (i % 17) == 3 ? 1 : 0);
        end
        rst_n = 1'b0;
        m_elev = 0; m_fault = 0; m_cause = 0;
        @(negedge clk);
        compare("R1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule